// File: doc/BRIEF.md
# Negabinary-Weight Multiply-Accumulate with Bit-Serial Result

This block is the arithmetic core of one neuron. Each cycle it takes an 8-bit two's complement data value and an 8-bit weight written in base minus two, and it multiplies them in a three-stage pipeline. The product stays in carry-save form, as a sum word and a carry word. A carry-save accumulator folds each new product into a running pair of words, so no carry ever ripples inside the loop.

Operands are grouped into frames of up to 16 products. The producer raises a frame strobe together with the first operand of each frame. When that operand reaches the accumulator, the pair built up over the previous frame is copied into two shift registers and the accumulator starts again from the new product. A one-bit full adder with a carry flip-flop then resolves the copied pair into a 16-bit result, which leaves LSB first over the next 16 cycles. That serial output overlaps the accumulation of the following frame. The weight store and the activation function sit outside this block.

Top module: `nbm_mac`

## Requirements
- R1: A weight code w is decoded as the sum over the set bits w[i] of (-2)^i, so every one of the 256 codes is legal (0x55 is +85, 0xAA is -170, the trained range -150..85 lies inside). The product is data_in, read as two's complement, times this value.
- R2: An operand pair presented with in_valid low adds nothing to the frame sum, whatever its data and weight bits.
- R3: A new operand pair is accepted every cycle. All valid pairs of a frame, up to 16 in consecutive cycles, are summed.
- R4: A frame begins at the cycle in which frame_first is high. The result word produced at that strobe is the sum of the frame before it. The first strobe after reset produces zero.
- R5: A result word is sent LSB first on ser_bit. ser_valid stays high for exactly 16 consecutive cycles per word, and ser_first is high only on bit 0.
- R6: Bit 0 of a result word appears right after the fourth rising edge counted from, and including, the edge that samples its frame_first.
- R7: The frame sum is kept modulo 2^16. A sum outside the signed 16-bit range wraps.
- R8: The accumulator restarts at each strobe, so frame k+1 is unaffected by frame k even though the serial output of frame k runs during frame k+1.
- R9: While rst_n is low and after it rises, ser_valid stays low until the first frame_first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_first | input | 1 | High with the first operand of a frame |
| in_valid | input | 1 | Operand pair on data_in and weight_in is to be used |
| data_in | input | 8 | Data operand, two's complement |
| weight_in | input | 8 | Weight operand, negabinary digits, bit i weighs (-2)^i |
| ser_bit | output | 1 | Serial result bit, LSB first |
| ser_valid | output | 1 | ser_bit carries a result bit |
| ser_first | output | 1 | ser_bit carries bit 0 of a result word |

## Verification
A wrong partial-product sign or shift in the multiplier changes the word of the frame that holds the pair, and the scoreboard sees it 4 to 20 cycles after the operand is presented. A carry word that is dropped or misaligned, either in the accumulator or in the serial adder, shows up in the high bits of the serial word, and only for operand patterns that produce carries. The bench therefore includes the most negative data value against the most negative weight. A missed clear at the strobe passes one frame's sum into the next word, and a wrong serial counter shows up as a word that is not 16 bits long, or as a start that is not 4 cycles after the strobe.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
  localparam int unsigned NBM_DATA_W   = 8;
  localparam int unsigned NBM_WEIGHT_W = 8;
  localparam int unsigned NBM_ACC_W    = 16;
  localparam int unsigned NBM_STAGES   = 3;
endpackage

// File: rtl/nbm_mult.sv
module nbm_mult #(
  parameter int unsigned DW = 8,
  parameter int unsigned WW = 8,
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [DW-1:0] data,
  input  logic [WW-1:0] weight,
  output logic [AW-1:0] p_s,
  output logic [AW-1:0] p_c,
  output logic          p_first
);
  localparam int unsigned GRP = (WW + 3) / 4;
  localparam int unsigned NT  = GRP * 4;

  function automatic logic [2*AW-1:0] csa3(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                           input logic [AW-1:0] z);
    logic [AW-1:0] s;
    logic [AW-1:0] c;
    s = x ^ y ^ z;
    c = ((x & y) | (x & z) | (y & z)) << 1;
    return {s, c};
  endfunction

  function automatic logic [AW-1:0] ref_mul(input logic [DW-1:0] a, input logic [WW-1:0] w);
    int wv;
    int pw;
    wv = 0;
    pw = 1;
    for (int i = 0; i < int'(WW); i++) begin
      if (w[i]) wv = wv + pw;
      pw = pw * -2;
    end
    return AW'(int'($signed(a)) * wv);
  endfunction

  // stage 1: operand capture, idle slots forced to a zero product
  logic          s1_v, s1_f;
  logic [DW-1:0] s1_a;
  logic [WW-1:0] s1_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_f <= 1'b0;
      s1_a <= '0;
      s1_w <= '0;
    end else begin
      s1_v <= in_valid;
      s1_f <= in_first;
      s1_a <= in_valid ? data : '0;
      s1_w <= in_valid ? weight : '0;
    end
  end

  logic [AW-1:0] a_ext;
  logic [AW-1:0] term [NT];
  assign a_ext = {{(AW-DW){s1_a[DW-1]}}, s1_a};

  for (genvar i = 0; i < int'(NT); i++) begin : g_term
    if (i < int'(WW)) begin : g_live
      logic [AW-1:0] shifted;
      assign shifted = a_ext << i;
      if (i % 2 == 1) begin : g_neg
        assign term[i] = s1_w[i] ? ((~shifted) + AW'(1)) : '0;
      end else begin : g_pos
        assign term[i] = s1_w[i] ? shifted : '0;
      end
    end else begin : g_pad
      assign term[i] = '0;
    end
  end

  // stage 2: each group of four terms compressed to one carry-save pair
  logic [AW-1:0] grp_s [GRP];
  logic [AW-1:0] grp_c [GRP];
  logic [AW-1:0] s2_s  [GRP];
  logic [AW-1:0] s2_c  [GRP];
  logic          s2_f;

  for (genvar g = 0; g < int'(GRP); g++) begin : g_grp
    logic [AW-1:0] l1_s, l1_c;
    assign {l1_s, l1_c} = csa3(term[4*g], term[4*g+1], term[4*g+2]);
    assign {grp_s[g], grp_c[g]} = csa3(l1_s, l1_c, term[4*g+3]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_f <= 1'b0;
      for (int g = 0; g < int'(GRP); g++) begin
        s2_s[g] <= '0;
        s2_c[g] <= '0;
      end
    end else begin
      s2_f <= s1_f;
      for (int g = 0; g < int'(GRP); g++) begin
        s2_s[g] <= grp_s[g];
        s2_c[g] <= grp_c[g];
      end
    end
  end

  // stage 3: group pairs folded into a single product pair
  logic [AW-1:0] fold_s, fold_c;
  always_comb begin
    fold_s = s2_s[0];
    fold_c = s2_c[0];
    for (int g = 1; g < int'(GRP); g++) begin
      {fold_s, fold_c} = csa3(fold_s, fold_c, s2_s[g]);
      {fold_s, fold_c} = csa3(fold_s, fold_c, s2_c[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_s     <= '0;
      p_c     <= '0;
      p_first <= 1'b0;
    end else begin
      p_s     <= fold_s;
      p_c     <= fold_c;
      p_first <= s2_f;
    end
  end

  logic [AW-1:0] ref_prod;
  logic [AW-1:0] prod_total;
  assign ref_prod   = ref_mul(s1_a, s1_w);
  assign prod_total = p_s + p_c;

  // R1
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> ##1 (prod_total == $past(ref_prod, 2)));

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_v |=> ##1 (prod_total == '0));
endmodule

// File: rtl/nbm_acc.sv
module nbm_acc #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] p_s,
  input  logic [AW-1:0] p_c,
  input  logic          p_first,
  output logic          snap_load,
  output logic [AW-1:0] snap_s,
  output logic [AW-1:0] snap_c
);
  function automatic logic [2*AW-1:0] csa3(input logic [AW-1:0] x, input logic [AW-1:0] y,
                                           input logic [AW-1:0] z);
    logic [AW-1:0] s;
    logic [AW-1:0] c;
    s = x ^ y ^ z;
    c = ((x & y) | (x & z) | (y & z)) << 1;
    return {s, c};
  endfunction

  logic [AW-1:0] acc_s, acc_c;
  logic [AW-1:0] mid_s, mid_c, nxt_s, nxt_c;

  assign {mid_s, mid_c} = csa3(acc_s, acc_c, p_s);
  assign {nxt_s, nxt_c} = csa3(mid_s, mid_c, p_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_s <= '0;
      acc_c <= '0;
    end else if (p_first) begin
      acc_s <= p_s;
      acc_c <= p_c;
    end else begin
      acc_s <= nxt_s;
      acc_c <= nxt_c;
    end
  end

  assign snap_load = p_first;
  assign snap_s    = acc_s;
  assign snap_c    = acc_c;

  logic [AW-1:0] acc_total, prod_total;
  assign acc_total  = acc_s + acc_c;
  assign prod_total = p_s + p_c;

  // R8
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_first |=> (acc_total == $past(prod_total)));

  // R3
  fold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_first |=> (acc_total == AW'($past(acc_total) + $past(prod_total))));
endmodule

// File: rtl/nbm_ser.sv
module nbm_ser #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_s,
  input  logic [AW-1:0] ld_c,
  output logic          ser_bit,
  output logic          ser_valid,
  output logic          ser_first
);
  localparam int unsigned CW = (AW > 1) ? $clog2(AW) : 1;
  localparam logic [CW-1:0] LAST = CW'(AW - 1);

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  logic [AW-1:0] sh_s, sh_c;
  logic          cy, busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_s <= '0;
      sh_c <= '0;
      cy   <= 1'b0;
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      sh_s <= ld_s;
      sh_c <= ld_c;
      cy   <= 1'b0;
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      sh_s <= sh_s >> 1;
      sh_c <= sh_c >> 1;
      cy   <= maj3(sh_s[0], sh_c[0], cy);
      cnt  <= cnt + CW'(1);
      if (cnt == LAST) busy <= 1'b0;
    end
  end

  assign ser_bit   = sh_s[0] ^ sh_c[0] ^ cy;
  assign ser_valid = busy;
  assign ser_first = busy && (cnt == '0);

  // R6
  load_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser_first && !cy));

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && (cnt != LAST)) |=> ser_valid);

  // R5
  word_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && (cnt == LAST)) |=> !ser_valid);
endmodule

// File: rtl/nbm_mac.sv
module nbm_mac
  import nbm_pkg::*;
#(
  parameter int unsigned DW = NBM_DATA_W,
  parameter int unsigned WW = NBM_WEIGHT_W,
  parameter int unsigned AW = NBM_ACC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_first,
  input  logic          in_valid,
  input  logic [DW-1:0] data_in,
  input  logic [WW-1:0] weight_in,
  output logic          ser_bit,
  output logic          ser_valid,
  output logic          ser_first
);
  logic [AW-1:0] prod_s, prod_c;
  logic          prod_first;
  logic          snap_load;
  logic [AW-1:0] snap_s, snap_c;

  nbm_mult #(.DW(DW), .WW(WW), .AW(AW)) u_mult (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_first (frame_first),
    .data     (data_in),
    .weight   (weight_in),
    .p_s      (prod_s),
    .p_c      (prod_c),
    .p_first  (prod_first)
  );

  nbm_acc #(.AW(AW)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .p_s       (prod_s),
    .p_c       (prod_c),
    .p_first   (prod_first),
    .snap_load (snap_load),
    .snap_s    (snap_s),
    .snap_c    (snap_c)
  );

  nbm_ser #(.AW(AW)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (snap_load),
    .ld_s      (snap_s),
    .ld_c      (snap_c),
    .ser_bit   (ser_bit),
    .ser_valid (ser_valid),
    .ser_first (ser_first)
  );

  // R9
  quiet_until_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_valid && !snap_load) |=> !ser_first);
endmodule

// File: tb/tb_nbm_mac.sv
`timescale 1ns/1ps
module tb_nbm_mac;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_first = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] data_in = '0;
  logic [7:0] weight_in = '0;
  logic       ser_bit, ser_valid, ser_first;

  always #2 clk = ~clk;

  nbm_mac dut (
    .clk(clk), .rst_n(rst_n), .frame_first(frame_first), .in_valid(in_valid),
    .data_in(data_in), .weight_in(weight_in),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_first(ser_first)
  );

  typedef struct {
    logic [15:0] val;
    longint      cyc;
    string       tag;
  } exp_t;

  exp_t   sb_q[$];
  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  int     pending = 0;
  string  pend_tag = "R4";
  int unsigned lcg = 32'h1234_5678;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int nb_dec(input logic [7:0] w);
    int v = 0;
    int p = 1;
    for (int i = 0; i < 8; i++) begin
      if (w[i]) v += p;
      p = p * (-2);
    end
    return v;
  endfunction

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one operand slot, pushing the closed frame's expectation at a strobe
  task automatic put(input bit f, input bit v, input logic [7:0] d, input logic [7:0] w,
                     input string tag);
    @(negedge clk);
    frame_first = f;
    in_valid    = v;
    data_in     = d;
    weight_in   = w;
    if (f) begin
      exp_t e;
      e.val = 16'(pending);
      e.cyc = cyc + 4;
      e.tag = pend_tag;
      sb_q.push_back(e);
      pending  = 0;
      pend_tag = tag;
    end
    if (v) pending += int'($signed(d)) * nb_dec(w);
  endtask

  // monitor: collect serial words and compare against the scoreboard
  int     bitpos = 16;
  logic [15:0] word;
  exp_t   cur;
  always @(negedge clk) begin
    if (rst_n && ser_valid) begin
      if (ser_first) begin
        // R5 previous word must have been complete
        check(bitpos == 16, "R5 word length", bitpos, 16);
        bitpos = 0;
        word   = '0;
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected word", 1, 0);
          cur.val = '0; cur.cyc = cyc; cur.tag = "R4";
        end else begin
          cur = sb_q.pop_front();
          // R6 start cycle
          check(cyc == cur.cyc, "R6 latency", cyc, cur.cyc);
        end
      end
      if (bitpos < 16) begin
        word[bitpos] = ser_bit;
        bitpos++;
        if (bitpos == 16)
          check(word == cur.val, cur.tag, longint'(word), longint'(cur.val));
      end else begin
        check(1'b0, "R5 extra valid bit", 17, 16);
      end
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check(ser_valid == 1'b0, "R9 valid in reset", ser_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ser_valid == 1'b0 && ser_first == 1'b0, "R9 valid after reset", ser_valid, 0);

    // R1: all 256 weight codes, random data, 16 per frame
    for (int f = 0; f < 16; f++)
      for (int k = 0; k < 16; k++)
        put(k == 0, 1'b1, rnd8(), 8'(16 * f + k), "R1");

    // R7: most negative data times most negative weight wraps
    for (int k = 0; k < 16; k++) put(k == 0, 1'b1, 8'h80, 8'hAA, "R7 low wrap");
    for (int k = 0; k < 16; k++) put(k == 0, 1'b1, 8'h7F, 8'h55, "R7 high wrap");

    // R2: idle slots carry junk
    for (int k = 0; k < 16; k++) put(k == 0, k % 2 == 0, rnd8(), rnd8(), "R2");
    // R2: whole frame idle with frame strobe on an idle slot
    for (int k = 0; k < 16; k++) put(k == 0, 1'b0, 8'hFF, 8'hFF, "R2 idle frame");

    // R3: random back-to-back frames
    for (int f = 0; f < 4; f++)
      for (int k = 0; k < 16; k++) put(k == 0, 1'b1, rnd8(), rnd8(), "R3");

    // R8: single product after a large frame, then weight zero
    put(1'b1, 1'b1, 8'h05, 8'h03, "R8 single");
    for (int k = 1; k < 16; k++) put(1'b0, 1'b0, 8'h00, 8'h00, "R8 single");
    for (int k = 0; k < 16; k++) put(k == 0, 1'b1, rnd8(), 8'h00, "R8 zero weight");

    // flush the last frame and wait for idle
    put(1'b1, 1'b0, 8'h00, 8'h00, "R4 flush");
    put(1'b0, 1'b0, 8'h00, 8'h00, "R4 flush");
    repeat (40) @(negedge clk);
    check(sb_q.size() == 0, "R4 all words seen", sb_q.size(), 0);
    check(ser_valid == 1'b0, "R5 idle at end", ser_valid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule